// File: doc/BRIEF.md
# Sv32 Two-Level Address Translator

This block turns a 32-bit virtual address into a 34-bit physical address. It accepts one request at a time. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in User or Supervisor mode. When translation is on, the block walks a two-level page table. It reads each table entry through a simple memory request/response port and returns either a physical address or a page fault. It takes two further inputs as plain signals: the translation control value, made of a mode bit and the root table's page number, and the Supervisor-may-access-User-pages bit (SUM).

A table entry at either level may be a leaf. A leaf at the top level maps a 4 MiB megapage, and the low half of that page's number comes from the virtual address. The permission bits, the User bit and SUM decide whether a leaf may be used. When translation is off, the address passes straight through with no checks. The block keeps no cache and never writes back to the page table.

Top module: `sv32_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and both mem_req_valid_o and rsp_valid_o are 0.
- R2: When xlat_en_i is 0 at acceptance, the response gives paddr = {2'b00, vaddr} with no fault and no memory read, whatever the access type and privilege.
- R3: Entry layout: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, page number bits 31:10 (high part 31:20, low part 19:10). The top-level read goes to root_ppn*4096 + vaddr[31:22]*4. The second-level read goes to (pointer page number)*4096 + vaddr[21:12]*4. An address held while mem_req_ready_i is 0 stays stable.
- R4: A valid second-level leaf yields paddr = {entry page number, vaddr[11:0]} over the full 34 bits.
- R5: A valid top-level leaf (megapage) yields paddr = {entry[31:20], vaddr[21:12], vaddr[11:0]} after a single memory read.
- R6: An entry with V=0, or with W=1 and R=0, at either level gives a fault response.
- R7: An entry with R=0 and X=0 is a pointer at the top level. At the second level it gives a fault.
- R8: A top-level leaf with a nonzero entry[19:10] gives a fault.
- R9: Access code 0 (read) needs R, code 1 (write) needs W, and codes 2 and 3 (fetch) need X. A missing bit gives a fault.
- R10: A User-mode access (req_user_i=1) to a page with U=0 gives a fault. With U=1 it obeys R9 alone.
- R11: A Supervisor access to a U=1 page gives a fault for any fetch, and for reads and writes when sum_i is 0.
- R12: Each accepted request produces exactly one single-cycle rsp_valid_o pulse. req_ready_o is 0 from acceptance through that pulse, and at most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Block idle, request accepted on this edge |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2/3 fetch |
| req_user_i | input | 1 | 1 = User mode, 0 = Supervisor mode |
| xlat_en_i | input | 1 | Translation mode: 1 = two-level paging, 0 = pass-through |
| root_ppn_i | input | 22 | Page number of the top-level table |
| sum_i | input | 1 | Supervisor may read/write User pages |
| mem_req_valid_o | output | 1 | Table entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 34 | Physical address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 32 | Entry data |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_paddr_o | output | 34 | Translated physical address |
| rsp_fault_o | output | 1 | Page fault |

## Verification
A walker in the wrong state shows up at the memory port first. It may issue the wrong number of entry reads, read from the wrong table slot, or drop an address while stalled. Each of these is visible the cycle the read is issued. A mistake in the permission or format checks appears only at the result pulse, one cycle after the deciding entry returns. There it shows as a flipped fault bit or a wrong page number. Megapage and second-level results differ in where the middle ten address bits come from, so a level mix-up also shows in those bits.

// File: rtl/sv32_pkg.sv
package sv32_pkg;
  localparam int VA_W  = 32;
  localparam int PTE_W = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = 10;
  localparam int PPN_W = 22;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);

  // entry flag positions
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int PPN_LSB = 10;
  localparam int PPN1_LSB = PPN_LSB + VPN_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_FETCH_ALT = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L0_REQ, ST_L0_WAIT, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/sv32_pte_check.sv
module sv32_pte_check
  import sv32_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             top_lvl_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic             sum_i,
  output logic             ptr_o,
  output logic             fault_o
);
  logic v, r, w, x, u;
  logic bad_fmt, is_ptr, mega_misalign, perm_ok, priv_ok;

  assign v = pte_i[B_V];
  assign r = pte_i[B_R];
  assign w = pte_i[B_W];
  assign x = pte_i[B_X];
  assign u = pte_i[B_U];

  assign bad_fmt = !v || (w && !r);
  assign is_ptr  = !r && !x;
  assign mega_misalign = top_lvl_i && (pte_i[PPN1_LSB-1:PPN_LSB] != '0);

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  perm_ok = r;
      ACC_WRITE: perm_ok = w;
      default:   perm_ok = x;
    endcase
  end

  always_comb begin
    if (user_i) priv_ok = u;
    else if (u) priv_ok = sum_i && (acc_i[1] == 1'b0);
    else        priv_ok = 1'b1;
  end

  assign ptr_o = !bad_fmt && is_ptr && top_lvl_i;

  always_comb begin
    if (bad_fmt)         fault_o = 1'b1;
    else if (is_ptr)     fault_o = !top_lvl_i;
    else if (mega_misalign) fault_o = 1'b1;
    else                 fault_o = !(perm_ok && priv_ok);
  end
endmodule

// File: rtl/sv32_paddr_form.sv
module sv32_paddr_form
  import sv32_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             mega_i,
  output logic [PA_W-1:0]  paddr_o
);
  logic [VPN_W-1:0] low_ppn;

  // megapage: low page number comes from the virtual address
  assign low_ppn = mega_i ? vaddr_i[OFF_W +: VPN_W] : pte_i[PPN_LSB +: VPN_W];
  assign paddr_o = {pte_i[PTE_W-1:PPN1_LSB], low_ppn, vaddr_i[OFF_W-1:0]};
endmodule

// File: rtl/sv32_xlate.sv
module sv32_xlate
  import sv32_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_user_i,
  input  logic              xlat_en_i,
  input  logic [21:0]       root_ppn_i,
  input  logic              sum_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [33:0]       mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              rsp_valid_o,
  output logic [33:0]       rsp_paddr_o,
  output logic              rsp_fault_o
);
  walk_state_e state_q, state_d;
  logic [VA_W-1:0]  vaddr_q;
  logic [1:0]       acc_q;
  logic             user_q, sum_q, bare_q;
  logic [PPN_W-1:0] root_q, nxt_ppn_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;

  logic             top_lvl, chk_ptr, chk_fault;
  logic [PA_W-1:0]  leaf_pa;
  logic             in_wait, rsp_take;

  assign top_lvl  = (state_q == ST_L1_WAIT);
  assign in_wait  = (state_q == ST_L1_WAIT) || (state_q == ST_L0_WAIT);
  assign rsp_take = in_wait && mem_rsp_valid_i;

  sv32_pte_check u_chk (
    .pte_i     (mem_rsp_data_i),
    .top_lvl_i (top_lvl),
    .acc_i     (acc_q),
    .user_i    (user_q),
    .sum_i     (sum_q),
    .ptr_o     (chk_ptr),
    .fault_o   (chk_fault)
  );

  sv32_paddr_form u_pa (
    .pte_i   (mem_rsp_data_i),
    .vaddr_i (vaddr_q),
    .mega_i  (top_lvl),
    .paddr_o (leaf_pa)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = xlat_en_i ? ST_L1_REQ : ST_DONE;
      ST_L1_REQ:  if (mem_req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid_i) state_d = (!chk_fault && chk_ptr) ? ST_L0_REQ : ST_DONE;
      ST_L0_REQ:  if (mem_req_ready_i) state_d = ST_L0_WAIT;
      ST_L0_WAIT: if (mem_rsp_valid_i) state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      acc_q     <= '0;
      user_q    <= 1'b0;
      sum_q     <= 1'b0;
      bare_q    <= 1'b0;
      root_q    <= '0;
      nxt_ppn_q <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        acc_q   <= req_acc_i;
        user_q  <= req_user_i;
        sum_q   <= sum_i;
        root_q  <= root_ppn_i;
        bare_q  <= !xlat_en_i;
        if (!xlat_en_i) begin
          paddr_q <= {{(PA_W-VA_W){1'b0}}, req_vaddr_i};
          fault_q <= 1'b0;
        end
      end
      if (rsp_take) begin
        if (chk_fault) begin
          fault_q <= 1'b1;
          paddr_q <= '0;
        end else if (chk_ptr) begin
          nxt_ppn_q <= mem_rsp_data_i[PTE_W-1:PPN_LSB];
        end else begin
          fault_q <= 1'b0;
          paddr_q <= leaf_pa;
        end
      end
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L0_REQ);
  assign mem_req_addr_o  = (state_q == ST_L1_REQ)
                         ? {root_q,    vaddr_q[OFF_W+VPN_W +: VPN_W], {ENT_SH{1'b0}}}
                         : {nxt_ppn_q, vaddr_q[OFF_W +: VPN_W],       {ENT_SH{1'b0}}};
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;

  p_idle_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  p_rsp_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_one_outstanding_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> !mem_req_valid_o);
  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  p_bare_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && !xlat_en_i |=> !mem_req_valid_o && rsp_valid_o && !rsp_fault_o);
  p_invalid_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take && !mem_rsp_data_i[B_V] |=> rsp_valid_o && rsp_fault_o);
  p_mega_misalign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take && top_lvl && mem_rsp_data_i[B_V] && (mem_rsp_data_i[B_R] || mem_rsp_data_i[B_X])
      && (mem_rsp_data_i[PPN1_LSB-1:PPN_LSB] != '0) |=> rsp_fault_o);
  p_no_user_fetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take && !user_q && acc_q[1] && mem_rsp_data_i[B_U] && mem_rsp_data_i[B_X] |=> rsp_fault_o);
endmodule

// File: tb/tb_sv32_xlate.sv
module tb_sv32_xlate;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_user_i = 1'b0, xlat_en_i = 1'b1, sum_i = 1'b0;
  logic [21:0] root_ppn_i = 22'h00100;
  logic        mem_req_valid_o, mem_req_ready_i;
  logic [33:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [33:0] rsp_paddr_o;

  sv32_xlate dut (.*);

  int checks = 0, fails = 0;
  logic        gate = 1'b1;
  logic [31:0] cur_l1 = '0, cur_l0 = '0;
  int          rd_cnt = 0;
  logic [33:0] last_addr = '0, prev_addr = '0;

  localparam logic [33:0] L1_ADDR = 34'h0_0010_0004;
  localparam logic [33:0] L0_ADDR = 34'h0_0020_000C;
  localparam logic [31:0] VA = 32'h0040_3ABC;
  localparam logic [31:0] P  = 32'h0008_0001;
  localparam logic [33:0] PA = 34'h0_1234_5ABC;

  assign mem_req_ready_i = gate;

  // entry memory: top-level slot answers cur_l1, any other answers cur_l0
  always @(posedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      mem_rsp_valid_i <= 1'b1;
      mem_rsp_data_i  <= (mem_req_addr_o == L1_ADDR) ? cur_l1 : cur_l0;
      prev_addr <= last_addr;
      last_addr <= mem_req_addr_o;
      rd_cnt    <= rd_cnt + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  acc;
    logic        usr;
    logic        sum;
    logic [31:0] l1;
    logic [31:0] l0;
    logic        flt;
    logic [33:0] pa;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, P, 32'h048D1407, 1'b0, PA, 2'd2},
    '{2'd1, 1'b0, 1'b0, P, 32'h048D1407, 1'b0, PA, 2'd2},
    '{2'd2, 1'b0, 1'b0, P, 32'h048D1403, 1'b1, 34'h0, 2'd2},
    '{2'd1, 1'b0, 1'b0, P, 32'h048D1403, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b1, 1'b0, P, 32'h048D1407, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b1, 1'b0, P, 32'h048D1417, 1'b0, PA, 2'd2},
    '{2'd0, 1'b0, 1'b0, P, 32'h048D1417, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b0, 1'b1, P, 32'h048D1417, 1'b0, PA, 2'd2},
    '{2'd2, 1'b0, 1'b1, P, 32'h048D141B, 1'b1, 34'h0, 2'd2},
    '{2'd2, 1'b1, 1'b0, P, 32'h048D141B, 1'b0, PA, 2'd2},
    '{2'd0, 1'b0, 1'b0, P, 32'h048D1406, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b0, 1'b0, P, 32'h048D1405, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 34'h0, 2'd1},
    '{2'd0, 1'b0, 1'b0, P, P, 1'b1, 34'h0, 2'd2},
    '{2'd0, 1'b0, 1'b0, 32'h0AB00007, 32'h0, 1'b0, 34'h0_2AC0_3ABC, 2'd1},
    '{2'd0, 1'b0, 1'b0, 32'h0AB00407, 32'h0, 1'b1, 34'h0, 2'd1},
    '{2'd0, 1'b0, 1'b0, 32'h00080005, 32'h0, 1'b1, 34'h0, 2'd1},
    '{2'd0, 1'b0, 1'b0, P, 32'hFFFFFC07, 1'b0, 34'h3_FFFF_FABC, 2'd2},
    '{2'd3, 1'b1, 1'b0, 32'h0AB0001B, 32'h0, 1'b0, 34'h0_2AC0_3ABC, 2'd1}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 17:        return "R4";
      1, 2, 3:      return "R9";
      4, 5, 9:      return "R10";
      6, 7, 8:      return "R11";
      10, 11, 12, 16: return "R6";
      13:           return "R7";
      14, 18:       return "R5";
      default:      return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [33:0] got_pa;
  logic        got_flt;
  int          got_rd;

  task automatic run(input logic [31:0] va, input logic [1:0] acc,
                     input logic usr, input logic sm);
    int base, n;
    base = rd_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc;
    req_user_i = usr; sum_i = sm;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 0;
    while (!rsp_valid_o && n < 60) begin
      @(negedge clk_i);
      n++;
    end
    got_pa = rsp_paddr_o;
    got_flt = rsp_fault_o;
    got_rd = rd_cnt - base;
    chk(rsp_valid_o && !req_ready_o, "R12", "response seen, busy", {62'd0, rsp_valid_o, req_ready_o}, 64'h2);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R12", "single pulse then idle", {62'd0, rsp_valid_o, req_ready_o}, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1", "reset state",
        {61'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 64'h4);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cur_l1 = VECS[i].l1;
      cur_l0 = VECS[i].l0;
      run(VA, VECS[i].acc, VECS[i].usr, VECS[i].sum);
      chk(got_flt == VECS[i].flt, vec_req(i), $sformatf("vec %0d fault", i), 64'(got_flt), 64'(VECS[i].flt));
      if (!VECS[i].flt)
        chk(got_pa == VECS[i].pa, vec_req(i), $sformatf("vec %0d paddr", i), 64'(got_pa), 64'(VECS[i].pa));
      chk(got_rd == int'(VECS[i].nrd), "R3", $sformatf("vec %0d read count", i), 64'(got_rd), 64'(VECS[i].nrd));
      if (VECS[i].nrd == 2'd2) begin
        chk(prev_addr == L1_ADDR, "R3", "top-level entry address", 64'(prev_addr), 64'(L1_ADDR));
        if (VECS[i].l1 == P)
          chk(last_addr == L0_ADDR, "R3", "second-level entry address", 64'(last_addr), 64'(L0_ADDR));
      end else begin
        chk(last_addr == L1_ADDR, "R3", "top-level entry address", 64'(last_addr), 64'(L1_ADDR));
      end
    end

    // pass-through: no reads, no checks, even for a User write
    xlat_en_i = 1'b0;
    run(32'hDEAD_BEEF, 2'd1, 1'b1, 1'b0);
    chk(got_rd == 0, "R2", "bare read count", 64'(got_rd), 64'd0);
    chk(!got_flt && got_pa == 34'h0_DEAD_BEEF, "R2", "bare paddr", 64'(got_pa), 64'h0DEADBEEF);
    xlat_en_i = 1'b1;

    // stalled memory port holds the request
    cur_l1 = P; cur_l0 = 32'h048D1407;
    gate = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = VA; req_acc_i = 2'd0; req_user_i = 1'b0; sum_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(mem_req_valid_o && mem_req_addr_o == L1_ADDR && !req_ready_o, "R3", "stalled request held",
        64'(mem_req_addr_o), 64'(L1_ADDR));
    chk(!rsp_valid_o, "R12", "no response while stalled", 64'(rsp_valid_o), 64'd0);
    gate = 1'b1;
    begin
      int n = 0;
      while (!rsp_valid_o && n < 60) begin
        @(negedge clk_i);
        n++;
      end
    end
    chk(rsp_valid_o && !rsp_fault_o && rsp_paddr_o == PA, "R4", "result after stall",
        64'(rsp_paddr_o), 64'(PA));
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule